// File: doc/BRIEF.md
# Programmable Tap-Select Binary Timer

This block is a 24-stage binary divider that lives entirely in one system-clock domain. A slow timer input is brought in through a synchronizer. Each high-to-low transition of that input advances the divider chain by one count. A 4-bit tap code picks one of the upper sixteen stages, and that stage drives the decode output. The decode output either follows the chosen stage directly or gives a single system-clock pulse each time the stage rises.

A skip control removes the lowest eight stages from the count path. The timer input then clocks stage 9 directly, so every tap moves 256 times closer to the input. Two force inputs load the whole chain with zeros or with ones. A hold input freezes counting. When skip and both force inputs are high together, the chain enters a split test arrangement. In that arrangement it works as three 8-bit counters that all advance together. After 255 steps every stage is filled, and a single step back in the normal arrangement then rolls the whole chain to zero.

Top module: `tap_timer`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `stages_o` is all zeros and `dec_o` is 0.
- R2: Outside the force and test cases, each 1-to-0 change of `tmr_in` adds one to `stages_o`. The new value appears on the third rising `clk` edge after `tmr_in` changes: two synchronizer stages, then the counter register. A 0-to-1 change adds nothing.
- R3: While `hold_i` is 1, changes of `tmr_in` leave `stages_o` unchanged.
- R4: With `skip_i` = 1, bits 7:0 of `stages_o` stay constant. Bits 23:8 form the counter, and it advances by one on each falling edge.
- R5: With `direct_i` = 1, `dec_o` equals `stages_o[8 + tap_sel_i]`. Bits are numbered from 0, so code 0 gives bit 8 and code 15 gives bit 23.
- R6: With `direct_i` = 0, `dec_o` is high for exactly one `clk` cycle when the selected bit goes from 0 to 1, and is low otherwise.
- R7: `clear_i` = 1 gives all zeros at the next `clk` edge. If `skip_i` = 0, this holds even when `fill_i` is also 1.
- R8: `fill_i` = 1 with `clear_i` = 0 gives all ones at the next `clk` edge.
- R9: `skip_i`, `fill_i` and `clear_i` all at 1 select test mode. In test mode, bits 7:0, 15:8 and 23:16 are three separate counters. Each counts modulo 256 and each advances on every falling edge.
- R10: Starting from zero, 255 falling edges in test mode give all ones. If all three controls are then dropped in the same cycle, one more falling edge returns the chain to all zeros.
- R11: In normal mode, a falling edge on an all-ones chain wraps it to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_in | input | 1 | Timer input; its falling edges advance the chain |
| hold_i | input | 1 | Freezes counting while 1 |
| fill_i | input | 1 | Loads all ones |
| clear_i | input | 1 | Loads all zeros |
| skip_i | input | 1 | Removes the low eight stages from the count path |
| tap_sel_i | input | 4 | Chooses which upper stage drives the decode output |
| direct_i | input | 1 | 1: the tap passes straight through; 0: one-cycle pulse on each rising tap |
| dec_o | output | 1 | Decode output |
| stages_o | output | 24 | Full stage vector |

## Verification
The assertions assume that the control inputs change only between clock edges and stay stable across each edge. The one-pulse property also assumes that the tap code does not change during the cycle that follows a pulse. The stimulus changes every input two nanoseconds after a rising edge. In pulse mode it changes the tap code only while the chain is forced or idle. It drives `tmr_in` with high and low phases of three clocks each, so every edge gets through the synchronizer before the next one arrives.

// File: rtl/tap_timer_pkg.sv
`timescale 1ns/1ps
package tap_timer_pkg;

  typedef enum logic [1:0] {
    MODE_SERIAL = 2'd0,
    MODE_SKIP   = 2'd1,
    MODE_SPLIT  = 2'd2
  } chain_mode_e;

endpackage

// File: rtl/tt_edge_sync.sv
`timescale 1ns/1ps
// Synchronizes the timer input and flags its falling edge for one cycle.
module tt_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_i,
  output logic fall_o
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   last_q, last_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], din_i};
    last_d = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign fall_o = last_q & ~sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/tt_chain.sv
`timescale 1ns/1ps
// Sectioned counter: serial, skip-first-section, or split into parallel sections.
module tt_chain
  import tap_timer_pkg::*;
#(
  parameter  int SECTION_W     = 8,
  parameter  int N_SECTIONS    = 3,
  parameter  int SKIP_SECTIONS = 1,
  localparam int CHAIN_W       = SECTION_W * N_SECTIONS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  chain_mode_e        mode_i,
  input  logic               step_i,
  input  logic               clear_i,
  input  logic               fill_i,
  output logic [CHAIN_W-1:0] count_o
);

  logic [CHAIN_W-1:0]    count_q, count_d;
  logic [N_SECTIONS-1:0] inc;
  logic [N_SECTIONS-1:0] full;

  genvar s;
  generate
    for (s = 0; s < N_SECTIONS; s++) begin : g_full
      assign full[s] = &count_q[s*SECTION_W +: SECTION_W];
    end
  endgenerate

  // Per-section increment enables; the carry ripples upward between sections.
  always_comb begin
    logic carry;
    carry = 1'b0;
    for (int k = 0; k < N_SECTIONS; k++) begin
      if (mode_i == MODE_SPLIT) begin
        inc[k] = step_i;
      end else if (mode_i == MODE_SKIP && k < SKIP_SECTIONS) begin
        inc[k] = 1'b0;
      end else if (k == 0 || (mode_i == MODE_SKIP && k == SKIP_SECTIONS)) begin
        inc[k] = step_i;
      end else begin
        inc[k] = carry;
      end
      carry = inc[k] & full[k];
    end
  end

  always_comb begin
    if (clear_i) begin
      count_d = '0;
    end else if (fill_i) begin
      count_d = '1;
    end else begin
      for (int k = 0; k < N_SECTIONS; k++) begin
        count_d[k*SECTION_W +: SECTION_W] =
          count_q[k*SECTION_W +: SECTION_W] + SECTION_W'(inc[k]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/tt_tap.sv
`timescale 1ns/1ps
// Picks one stage, counted upward from OFFSET.
module tt_tap #(
  parameter  int CHAIN_W = 24,
  parameter  int OFFSET  = 8,
  parameter  int SEL_W   = 4,
  localparam int PAD_W   = (OFFSET + (1 << SEL_W) > CHAIN_W) ?
                           OFFSET + (1 << SEL_W) : CHAIN_W
) (
  input  logic [CHAIN_W-1:0] stages_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               tap_o
);

  logic [PAD_W-1:0] padded;

  always_comb begin
    padded = '0;
    padded[CHAIN_W-1:0] = stages_i;
    tap_o = padded[OFFSET + int'(sel_i)];
  end

endmodule

// File: rtl/tt_decode.sv
`timescale 1ns/1ps
// Decode output: direct pass-through or a one-cycle pulse on each tap rise.
module tt_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic tap_i,
  input  logic direct_i,
  output logic dec_o
);

  logic tap_q, tap_d;

  always_comb tap_d = tap_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q <= 1'b0;
    end else begin
      tap_q <= tap_d;
    end
  end

  assign dec_o = direct_i ? tap_i : (tap_i & ~tap_q);

endmodule

// File: rtl/tap_timer.sv
`timescale 1ns/1ps
module tap_timer
  import tap_timer_pkg::*;
#(
  parameter  int SECTION_W   = 8,
  parameter  int N_SECTIONS  = 3,
  parameter  int SYNC_STAGES = 2,
  localparam int CHAIN_W     = SECTION_W * N_SECTIONS,
  localparam int SEL_W       = $clog2(CHAIN_W - SECTION_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tmr_in,
  input  logic               hold_i,
  input  logic               fill_i,
  input  logic               clear_i,
  input  logic               skip_i,
  input  logic [SEL_W-1:0]   tap_sel_i,
  input  logic               direct_i,
  output logic               dec_o,
  output logic [CHAIN_W-1:0] stages_o
);

  logic        fall;
  logic        split;
  logic        step;
  logic        clear_eff;
  logic        fill_eff;
  logic        tap;
  chain_mode_e mode;

  tt_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din_i  (tmr_in),
    .fall_o (fall)
  );

  // Control decode: test arrangement first, then clear over fill.
  always_comb begin
    split     = skip_i & fill_i & clear_i;
    clear_eff = clear_i & ~split;
    fill_eff  = fill_i & ~clear_i;
    step      = fall & ~hold_i;
    if (split)       mode = MODE_SPLIT;
    else if (skip_i) mode = MODE_SKIP;
    else             mode = MODE_SERIAL;
  end

  tt_chain #(
    .SECTION_W     (SECTION_W),
    .N_SECTIONS    (N_SECTIONS),
    .SKIP_SECTIONS (1)
  ) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode),
    .step_i  (step),
    .clear_i (clear_eff),
    .fill_i  (fill_eff),
    .count_o (stages_o)
  );

  tt_tap #(
    .CHAIN_W (CHAIN_W),
    .OFFSET  (SECTION_W),
    .SEL_W   (SEL_W)
  ) u_tap (
    .stages_i (stages_o),
    .sel_i    (tap_sel_i),
    .tap_o    (tap)
  );

  tt_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .tap_i    (tap),
    .direct_i (direct_i),
    .dec_o    (dec_o)
  );

endmodule

// File: rtl/tap_timer_chk.sv
`timescale 1ns/1ps
module tap_timer_chk #(
  parameter int CHAIN_W   = 24,
  parameter int SECTION_W = 8,
  parameter int SEL_W     = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hold_i,
  input logic               fill_i,
  input logic               clear_i,
  input logic               skip_i,
  input logic [SEL_W-1:0]   tap_sel_i,
  input logic               direct_i,
  input logic               dec_o,
  input logic [CHAIN_W-1:0] stages_o
);

  localparam logic [CHAIN_W-1:0] ONE_C = CHAIN_W'(1);

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !(skip_i && fill_i)) |=> (stages_o == '0)); // R7

  AST_FILL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_i && !clear_i) |=> (stages_o == '1)); // R8

  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !fill_i && !clear_i) |=> $stable(stages_o)); // R3

  AST_SKIP_LOW_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_i && !fill_i && !clear_i) |=> $stable(stages_o[SECTION_W-1:0])); // R4

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_i && !clear_i && !skip_i) |=>
      (stages_o == $past(stages_o) || stages_o == $past(stages_o) + ONE_C)); // R2

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!direct_i && dec_o) ##1 ($stable(tap_sel_i) && !direct_i) |-> !dec_o); // R6

  AST_DIRECT_TAP: assert property (@(posedge clk) disable iff (!rst_n)
    direct_i |-> (dec_o == stages_o[SECTION_W + int'(tap_sel_i)])); // R5

endmodule

bind tap_timer tap_timer_chk #(
  .CHAIN_W   (CHAIN_W),
  .SECTION_W (SECTION_W),
  .SEL_W     (SEL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hold_i    (hold_i),
  .fill_i    (fill_i),
  .clear_i   (clear_i),
  .skip_i    (skip_i),
  .tap_sel_i (tap_sel_i),
  .direct_i  (direct_i),
  .dec_o     (dec_o),
  .stages_o  (stages_o)
);

// File: tb/tap_timer_test.sv
`timescale 1ns/1ps
module tap_timer_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tmr_in;
  logic        hold_i, fill_i, clear_i, skip_i, direct_i;
  logic [3:0]  tap_sel_i;
  logic        dec_o;
  logic [23:0] stages_o;

  int n_checks = 0;
  int n_fails  = 0;
  int pulses   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  tap_timer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmr_in    (tmr_in),
    .hold_i    (hold_i),
    .fill_i    (fill_i),
    .clear_i   (clear_i),
    .skip_i    (skip_i),
    .tap_sel_i (tap_sel_i),
    .direct_i  (direct_i),
    .dec_o     (dec_o),
    .stages_o  (stages_o)
  );

  // Behavioural reference model
  logic [23:0] m_cnt;
  bit          m_tap_prev;
  bit          hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 24'd0;
      m_tap_prev = 1'b0;
      hist.delete();
    end else begin
      int  n;
      bit  cur, prv, fall;
      n   = hist.size();
      cur = (n >= 2) ? hist[n-2] : 1'b0;
      prv = (n >= 3) ? hist[n-3] : 1'b0;
      fall = prv && !cur && !hold_i;
      m_tap_prev = m_cnt[8 + tap_sel_i];
      if (skip_i && fill_i && clear_i) begin
        if (fall)
          for (int k = 0; k < 3; k++) m_cnt[k*8 +: 8] = m_cnt[k*8 +: 8] + 8'd1;
      end else if (clear_i) begin
        m_cnt = 24'd0;
      end else if (fill_i) begin
        m_cnt = 24'hFFFFFF;
      end else if (fall) begin
        if (skip_i) m_cnt[23:8] = m_cnt[23:8] + 16'd1;
        else        m_cnt = m_cnt + 24'd1;
      end
      hist.push_back(tmr_in);
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      bit t;
      t = m_cnt[8 + tap_sel_i];
      check("R2 stage vector vs model", stages_o, m_cnt);
      if (direct_i) check("R5 direct decode vs model", {23'd0, dec_o}, {23'd0, t});
      else          check("R6 pulse decode vs model", {23'd0, dec_o}, {23'd0, t & ~m_tap_prev});
      if (dec_o === 1'b1) pulses++;
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic falling();
    tmr_in = 1'b1;
    repeat (3) tick();
    tmr_in = 1'b0;
    repeat (3) tick();
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tmr_in = 1'b1; hold_i = 0; fill_i = 0; clear_i = 0;
    skip_i = 0; direct_i = 1; tap_sel_i = 4'd0;
    repeat (3) tick();
    @(negedge clk);
    check("R1 stages in reset", stages_o, 24'd0);
    check("R1 decode in reset", {23'd0, dec_o}, 24'd0);
    tick();
    rst_n = 1'b1;
    tick();
    @(negedge clk);
    check("R1 stages after release", stages_o, 24'd0);

    // R2: exact latency of one falling edge
    repeat (3) tick();
    tmr_in = 1'b0;
    tick(); tick();
    @(negedge clk);
    check("R2 no change two edges after fall", stages_o, 24'd0);
    tick();
    @(negedge clk);
    check("R2 count on third edge", stages_o, 24'd1);
    repeat (2) tick();
    for (int i = 0; i < 4; i++) falling();
    check("R2 five falling edges", stages_o, 24'd5);
    tmr_in = 1'b1;
    repeat (5) tick();
    @(negedge clk);
    check("R2 rising edge ignored", stages_o, 24'd5);

    // R3: hold
    hold_i = 1'b1;
    for (int i = 0; i < 3; i++) falling();
    @(negedge clk);
    check("R3 hold freezes chain", stages_o, 24'd5);
    hold_i = 1'b0;

    // R4: skip low section
    skip_i = 1'b1;
    for (int i = 0; i < 4; i++) falling();
    @(negedge clk);
    check("R4 skip counts upper stages", stages_o, 24'h000405);

    // R5: tap code 2 selects bit 10
    tap_sel_i = 4'd2;
    tick();
    @(negedge clk);
    check("R5 tap bit 10", {23'd0, dec_o}, 24'd1);
    tap_sel_i = 4'd1;
    tick();
    @(negedge clk);
    check("R5 tap bit 9", {23'd0, dec_o}, 24'd0);
    skip_i = 1'b0;

    // R7: clear beats fill
    clear_i = 1'b1; fill_i = 1'b1;
    tick();
    @(negedge clk);
    check("R7 clear over fill", stages_o, 24'd0);
    clear_i = 1'b0;
    tick();
    @(negedge clk);
    check("R8 fill loads ones", stages_o, 24'hFFFFFF);
    fill_i = 1'b0;

    // R11: wrap in normal mode
    falling();
    @(negedge clk);
    check("R11 wrap to zero", stages_o, 24'd0);

    // R6: pulses on stage 9 rising (bit 8), skip mode
    clear_i = 1'b1;
    tick();
    clear_i = 1'b0; skip_i = 1'b1; direct_i = 1'b0; tap_sel_i = 4'd0;
    repeat (2) tick();
    pulses = 0;
    for (int i = 0; i < 4; i++) falling();
    @(negedge clk);
    check("R6 two pulses over four edges", 24'(pulses), 24'd2);
    direct_i = 1'b1;

    // R9/R10: split test arrangement
    skip_i = 1'b0; clear_i = 1'b1;
    tick();
    skip_i = 1'b1; fill_i = 1'b1;
    tick();
    @(negedge clk);
    check("R9 enter test mode keeps value", stages_o, 24'd0);
    for (int i = 0; i < 3; i++) falling();
    @(negedge clk);
    check("R9 sections count in parallel", stages_o, 24'h030303);
    for (int i = 0; i < 252; i++) falling();
    @(negedge clk);
    check("R10 all ones after 255 edges", stages_o, 24'hFFFFFF);
    skip_i = 1'b0; fill_i = 1'b0; clear_i = 1'b0;
    tick();
    @(negedge clk);
    check("R10 release holds ones", stages_o, 24'hFFFFFF);
    falling();
    @(negedge clk);
    check("R10 one edge rolls to zero", stages_o, 24'd0);

    finish_run();
  end

endmodule